// File: doc/BRIEF.md
# Four-Mode Self-Test Register

A bank of W flip-flops whose next-state logic is chosen by two mode pins. Depending on the mode pair, the bank is cleared, captures a parallel word from the logic that feeds it, shifts serially between a scan input and a scan output, or runs as a multiple-input signature register. That last mode is a shift register with linear feedback whose stages also fold in the parallel input word. If the parallel input is held at zero, the signature register behaves as a free-running pseudorandom pattern source.

Two copies are normally placed around two blocks of combinational logic. In one test phase, the first copy is held at a constant input and supplies patterns to logic block A. The second copy compacts the responses of block A. In the next phase the roles are reversed. The mode pins are plain control inputs driven by an outside test sequencer. Mode changes take effect at the next rising clock edge. The register has no handshake and no back-pressure: it acts on its inputs at every clock edge.

The mode pair is written {mode_hi, mode_lo}. Stage 0 is the first stage of the chain and stage W-1 is the last. The feedback polynomial is given by the parameter TAPS: bit k-1 of TAPS set means the term x^k is present, and stage k-1 feeds the XOR. The default is W=4 with TAPS=4'b1100, which gives x^4 + x^3 + 1.

Top module: `bilbo_reg`

## Requirements
- R1: With mode {hi,lo}=00, every stage is 0 after the next rising edge.
- R2: With mode 01, the register captures par_in at the next rising edge.
- R3: With mode 10, the next state is stage 0 ← scan_in and stage i ← stage i-1 for i ≥ 1; par_in has no effect.
- R4: scan_out equals stage W-1 in every mode and at every moment.
- R5: With mode 11, the next state is stage 0 ← fb XOR par_in[0] and stage i ← stage i-1 XOR par_in[i] for i ≥ 1; scan_in has no effect.
- R6: fb is the XOR of the stages selected by TAPS. With the defaults this is stage 3 XOR stage 2, so the seed 4'b0001 with a zero input steps to 4'b0010, and the seed 4'b1000 steps to 4'b0001.
- R7: With the default polynomial, mode 11 and par_in held at 0, any nonzero seed visits 15 distinct nonzero states and returns to the seed after exactly 15 edges.
- R8: With mode 11, an all-zero state with par_in at 0 stays all-zero, so a nonzero seed must first be loaded by scan or by parallel capture.
- R9: rst_n low clears all stages at once, without waiting for a clock edge.
- R10: par_out always shows the current contents of all stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode_hi | input | 1 | Upper mode bit |
| mode_lo | input | 1 | Lower mode bit |
| par_in | input | W | Parallel word from the logic that feeds the register |
| scan_in | input | 1 | Serial input to stage 0 |
| par_out | output | W | Contents of all stages |
| scan_out | output | 1 | Last stage (W-1) |

## Verification
The bound checker verifies the per-edge transfer function of each mode on every cycle. It also checks that the serial output always tracks the last stage and that the all-zero state does not leave signature mode while the input is zero. Properties that span many edges can only be shown by the bench's scenarios. These are the full 15-state cycle and the first return to the seed. They also include the bit order of a complete scan load, the immediate effect of the asynchronous clear between edges, and the independence of the result from the unused input in each mode.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'b00,
    MODE_LOAD  = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_SIG   = 2'b11
  } bilbo_mode_e;

endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
  import bilbo_pkg::*;
(
  input  logic        mode_hi,
  input  logic        mode_lo,
  output bilbo_mode_e mode
);
  always_comb begin
    unique case ({mode_hi, mode_lo})
      2'b00:   mode = MODE_CLEAR;
      2'b01:   mode = MODE_LOAD;
      2'b10:   mode = MODE_SHIFT;
      default: mode = MODE_SIG;
    endcase
  end
endmodule

// File: rtl/bilbo_fb.sv
module bilbo_fb #(
  parameter int             W    = 4,
  parameter logic [W-1:0]   TAPS = W'(4'b1100)
) (
  input  logic [W-1:0] state,
  output logic         fb
);
  logic [W-1:0] gated;

  for (genvar k = 0; k < W; k++) begin : g_tap
    if (TAPS[k]) begin : g_on
      assign gated[k] = state[k];
    end else begin : g_off
      assign gated[k] = 1'b0;
    end
  end

  assign fb = ^gated;
endmodule

// File: rtl/bilbo_cell.sv
module bilbo_cell
  import bilbo_pkg::*;
(
  input  bilbo_mode_e mode,
  input  logic        d,
  input  logic        chain,
  output logic        nxt
);
  always_comb begin
    unique case (mode)
      MODE_CLEAR: nxt = 1'b0;
      MODE_LOAD:  nxt = d;
      MODE_SHIFT: nxt = chain;
      default:    nxt = chain ^ d;
    endcase
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int           W    = 4,
  parameter logic [W-1:0] TAPS = W'(4'b1100)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_hi,
  input  logic         mode_lo,
  input  logic [W-1:0] par_in,
  input  logic         scan_in,
  output logic [W-1:0] par_out,
  output logic         scan_out
);
  localparam int LAST = W - 1;

  bilbo_mode_e  mode;
  logic         fb;
  logic         head;
  logic [W-1:0] q;
  logic [W-1:0] q_nxt;
  logic [W-1:0] chain;

  bilbo_mode_dec u_dec (
    .mode_hi (mode_hi),
    .mode_lo (mode_lo),
    .mode    (mode)
  );

  bilbo_fb #(.W(W), .TAPS(TAPS)) u_fb (
    .state (q),
    .fb    (fb)
  );

  // Stage 0 takes the serial input while scanning, the feedback otherwise.
  assign head = (mode == MODE_SHIFT) ? scan_in : fb;

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign chain[i] = head;
    end else begin : g_rest
      assign chain[i] = q[i-1];
    end

    bilbo_cell u_cell (
      .mode  (mode),
      .d     (par_in[i]),
      .chain (chain[i]),
      .nxt   (q_nxt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign par_out  = q;
  assign scan_out = q[LAST];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
  parameter int           W    = 4,
  parameter logic [W-1:0] TAPS = W'(4'b1100)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_hi,
  input logic         mode_lo,
  input logic [W-1:0] par_in,
  input logic         scan_in,
  input logic [W-1:0] par_out,
  input logic         scan_out
);
  function automatic logic fb_of(logic [W-1:0] s);
    return ^(s & TAPS);
  endfunction

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && !mode_lo) |=> (par_out == '0));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && mode_lo) |=> (par_out == $past(par_in)));

  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && !mode_lo) |=>
      (par_out == {$past(par_out[W-2:0]), $past(scan_in)}));

  a_r4_tail: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out == par_out[W-1]);

  a_r5_sig: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && mode_lo) |=>
      (par_out == ({$past(par_out[W-2:0]), fb_of($past(par_out))} ^ $past(par_in))));

  a_r8_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && mode_lo && par_out == '0 && par_in == '0) |=> (par_out == '0));
endmodule

bind bilbo_reg bilbo_reg_chk #(.W(W), .TAPS(TAPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_hi  (mode_hi),
  .mode_lo  (mode_lo),
  .par_in   (par_in),
  .scan_in  (scan_in),
  .par_out  (par_out),
  .scan_out (scan_out)
);

// File: tb/sim_bilbo_reg.sv
module sim_bilbo_reg;
  localparam int         CLK_PERIOD = 10;
  localparam int         W          = 4;
  localparam logic [3:0] TAPS       = 4'b1100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_hi = 1'b0, mode_lo = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] par_out;
  logic         scan_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] mq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bilbo_reg #(.W(W), .TAPS(TAPS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .par_in(par_in), .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] model(logic [1:0] m, logic [W-1:0] q,
                                         logic [W-1:0] d, logic si);
    logic f;
    f = q[3] ^ q[2];
    case (m)
      2'b00:   return '0;
      2'b01:   return d;
      2'b10:   return {q[W-2:0], si};
      default: return {q[W-2:0], f} ^ d;
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One clock with the given inputs; called at a falling edge, returns at the next.
  task automatic step(logic [1:0] m, logic [W-1:0] d, logic si);
    {mode_hi, mode_lo} = m;
    par_in  = d;
    scan_in = si;
    @(negedge clk);
    mq = model(m, mq, d, si);
  endtask

  task automatic t_reset;
    chk("R9 reset par_out", par_out, '0);
    chk("R4 reset scan_out", {3'b0, scan_out}, 4'b0);
  endtask

  task automatic t_load;
    step(2'b01, 4'b1010, 1'b1);
    chk("R2 capture 1010", par_out, 4'b1010);
    chk("R10 par_out", par_out, mq);
    step(2'b01, 4'b0111, 1'b0);
    chk("R2 capture 0111", par_out, 4'b0111);
    step(2'b01, 4'b1111, 1'b0);
    chk("R2 capture 1111", par_out, mq);
    chk("R4 tail in load", {3'b0, scan_out}, {3'b0, mq[3]});
  endtask

  task automatic t_clear;
    step(2'b00, 4'b1111, 1'b1);
    chk("R1 clear", par_out, 4'b0000);
  endtask

  task automatic t_scan;
    logic [3:0] bits = 4'b1101;
    for (int i = 0; i < 4; i++) begin
      step(2'b10, 4'b1111, bits[i]);
      chk("R3 shift", par_out, mq);
      chk("R4 tail in shift", {3'b0, scan_out}, {3'b0, mq[3]});
    end
    chk("R3 scan load order", par_out, 4'b1011);
  endtask

  task automatic t_sig;
    step(2'b01, 4'b0001, 1'b0);
    step(2'b11, 4'b0000, 1'b1);
    chk("R6 seed 0001 step", par_out, 4'b0010);
    step(2'b01, 4'b1000, 1'b0);
    step(2'b11, 4'b0000, 1'b0);
    chk("R6 seed 1000 step", par_out, 4'b0001);
    step(2'b11, 4'b0110, 1'b1);
    chk("R5 fold 0110", par_out, mq);
    step(2'b11, 4'b1011, 1'b0);
    chk("R5 fold 1011", par_out, mq);
    step(2'b11, 4'b1111, 1'b1);
    chk("R5 fold 1111", par_out, mq);
    chk("R4 tail in sig", {3'b0, scan_out}, {3'b0, mq[3]});
  endtask

  task automatic t_gen;
    logic [W-1:0] seed;
    logic [15:0]  seen = '0;
    int           first_ret = 0;
    for (int i = 0; i < 4; i++) step(2'b10, 4'b0000, (i == 0));
    seed = par_out;
    chk("R7 seed via scan", seed, 4'b1000);
    for (int n = 1; n <= 15; n++) begin
      step(2'b11, 4'b0000, 1'b0);
      if (par_out == seed && first_ret == 0) first_ret = n;
      if (par_out == '0) chk("R7 never zero", par_out, 4'b1111);
      seen[par_out] = 1'b1;
    end
    chk("R7 first return after 15", 4'(first_ret), 4'd15);
    chk("R7 distinct states", 4'($countones(seen) - 1), 4'd14);
  endtask

  task automatic t_stuck;
    step(2'b00, 4'b0000, 1'b0);
    for (int i = 0; i < 5; i++) step(2'b11, 4'b0000, 1'b1);
    chk("R8 zero stays zero", par_out, 4'b0000);
  endtask

  task automatic t_async;
    step(2'b01, 4'b1001, 1'b0);
    #2 rst_n = 1'b0;
    #1 chk("R9 async clear", par_out, 4'b0000);
    mq = '0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 held after release", par_out, 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load();
    t_clear();
    t_scan();
    t_sig();
    t_gen();
    t_stuck();
    t_async();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule